// File: doc/BRIEF.md
# Configurable Direct-Mapped Cache Controller

This block is a direct-mapped cache of 8 Kbytes (512 lines of 16 bytes) that sits between a processor's request port and one shared backing-memory port. A two-bit mode input picks one of three arrangements. In the first, only instruction fetches are cached. In the second, only operand accesses are cached, with write-through stores. In the third, the split arrangement, one half of the arrays serves instructions and the other half serves operands. A fourth code turns caching off.

A read that hits is answered in the cycle it is presented, because the tag and data arrays are read side by side. A read miss on a cached type loads the whole line. The line arrives from memory as four 32-bit beats in ascending order and is collected in a line buffer. There is one such buffer for instructions and another for operands. The line is written into the arrays when the last beat arrives, and the held request then hits. Every store goes to memory. A store that hits also updates the cached word, and a store that misses allocates nothing. Accesses of a type the current mode does not cache go straight to memory as single beats. Only one memory access is in flight at a time.

The processor port is a hold-until-ready handshake: the request and its fields stay steady until a cycle in which `cpu_ready` is high. The memory port works the same way, with `mem_req` held and one `mem_ack` per beat.

Top module: `cache_ctrl`

## Requirements
- R1: A cacheable read whose line is valid, with an equal tag, raises `cpu_ready` in its first cycle with the stored word on `cpu_rdata`, and memory is not requested.
- R2: A cacheable read miss issues four memory reads at line base +0, +4, +8 and +12, in that order, one per acknowledged beat. In the cycle after the fourth acknowledge the request is answered as a hit, so a miss with zero-wait memory takes 6 cycles.
- R3: Mode 2'b00 caches only instruction fetches (`cpu_ifetch`=1) and mode 2'b01 caches only operand accesses. In both, the line index is address bits [12:4] (INDEX_W bits above the 4 offset bits) and the tag is the bits above them, so addresses one array-size apart evict each other.
- R4: Mode 2'b10 is the split mode. The top index bit is 1 for instruction fetches and 0 for operand accesses, the remaining index bits are address [11:4], and the tag is bits [31:12]. An instruction line and an operand line at the same address coexist.
- R5: Every store (`cpu_wr`=1) issues exactly one memory write carrying the request's address and data, and `cpu_ready` rises in the cycle that write is acknowledged (2 cycles with zero-wait memory).
- R6: A store that hits a cached line updates that word. A store that misses changes no line, so a later read of another address in the line it maps to still hits.
- R7: A request of a type the mode does not cache (mode 2'b11 caches nothing) is one memory beat, answered in its acknowledge cycle with the memory data (2 cycles), and allocates no line.
- R8: A cycle with `flush_all` high invalidates every line. A request presented in that cycle is not answered in it.
- R9: A change of `cfg_mode` invalidates every line and stalls an idle request for one cycle, so the first access after a change takes one cycle more.
- R10: At most one memory access is outstanding. While `mem_req` is high and not acknowledged, `mem_addr` holds steady.
- R11: After reset, `mem_req` and `cpu_ready` are low and no line is valid.
- R12: While a line fill is in progress, `cpu_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 00 instruction-only, 01 operand-only, 10 split, 11 no caching |
| flush_all | input | 1 | Invalidate every line |
| cpu_req | input | 1 | Request valid, held until ready |
| cpu_addr | input | ADDR_W | Byte address, word aligned |
| cpu_wr | input | 1 | 1 for a store |
| cpu_ifetch | input | 1 | 1 for an instruction fetch, 0 for an operand access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wr | output | 1 | 1 for a memory write |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Beat accepted or returned this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
The assertions assume that the processor holds its request fields steady until `cpu_ready`, never raises `cpu_wr` together with `cpu_ifetch`, and that `mem_ack` only occurs while `mem_req` is high. They also assume that `flush_all` and mode changes arrive while no store is waiting for memory. The stimulus drives the request fields at the falling edge and drops `cpu_req` right after the ready cycle. Its memory model acknowledges only a request it observed, and the bench changes mode or pulses flush only when the processor side is idle or presenting a new request.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam logic [1:0] MODE_INSN  = 2'b00;
  localparam logic [1:0] MODE_OPND  = 2'b01;
  localparam logic [1:0] MODE_SPLIT = 2'b10;
  localparam logic [1:0] MODE_NONE  = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_FILL   = 2'b01,
    ST_SINGLE = 2'b10
  } ctl_state_e;

  // Whether a request of the given type is held in the cache under mode m.
  function automatic logic mode_caches(input logic [1:0] m, input logic ifc);
    case (m)
      MODE_INSN:  return ifc;
      MODE_OPND:  return !ifc;
      MODE_SPLIT: return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cache_index_map.sv
module cache_index_map #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 4,
  parameter int INDEX_W = 9,
  localparam int TAG_W  = ADDR_W - OFF_W - INDEX_W + 1
) (
  input  logic                  split,
  input  logic                  ifetch,
  input  logic [ADDR_W-1:OFF_W] addr_hi,
  output logic [INDEX_W-1:0]    line_idx,
  output logic [TAG_W-1:0]      tag
);
  // The tag always keeps the bit just above a split index; unified compare drops it.
  assign tag = addr_hi[ADDR_W-1:OFF_W+INDEX_W-1];

  always_comb begin
    if (split) line_idx = {ifetch, addr_hi[OFF_W+INDEX_W-2:OFF_W]};
    else       line_idx = addr_hi[OFF_W+INDEX_W-1:OFF_W];
  end
endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int INDEX_W = 9,
  parameter int TAG_W   = 20,
  localparam int ENTRIES = 1 << INDEX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inval_all,
  input  logic               split,
  input  logic [INDEX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0]   rd_tag,
  output logic               hit,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag
);
  logic [TAG_W-1:0]   tags [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   stored;
  logic               match;

  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          valid_q <= '0;
    else if (inval_all)  valid_q <= '0;
    else if (wr_en)      valid_q[wr_idx] <= 1'b1;
  end

  always_comb begin
    stored = tags[rd_idx];
    if (split) match = (stored == rd_tag);
    else       match = (stored[TAG_W-1:1] == rd_tag[TAG_W-1:1]);
    hit = valid_q[rd_idx] && match;
  end
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int INDEX_W    = 9,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int WIDX_W = INDEX_W + WSEL_W,
  localparam int DEPTH  = 1 << WIDX_W
) (
  input  logic                         clk,
  input  logic [WIDX_W-1:0]            rd_widx,
  output logic [DATA_W-1:0]            rd_word,
  input  logic                         line_we,
  input  logic [INDEX_W-1:0]           line_idx,
  input  logic [LINE_WORDS*DATA_W-1:0] line_data,
  input  logic                         word_we,
  input  logic [DATA_W-1:0]            word_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (line_we) begin
      for (int k = 0; k < LINE_WORDS; k++)
        mem[{line_idx, WSEL_W'(k)}] <= line_data[k*DATA_W +: DATA_W];
    end else if (word_we) begin
      mem[rd_widx] <= word_data;
    end
  end

  assign rd_word = mem[rd_widx];
endmodule

// File: rtl/cache_fill_buf.sv
module cache_fill_buf #(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int WSEL_W = $clog2(LINE_WORDS)
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [WSEL_W-1:0]            sel,
  input  logic [DATA_W-1:0]            wdata,
  output logic [LINE_WORDS*DATA_W-1:0] line
);
  logic [DATA_W-1:0] words [LINE_WORDS];

  always_ff @(posedge clk) begin
    if (we) words[sel] <= wdata;
  end

  // The beat arriving this cycle is already visible, so the final beat needs no extra cycle.
  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_view
    assign line[k*DATA_W +: DATA_W] = (we && sel == WSEL_W'(k)) ? wdata : words[k];
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int INDEX_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              flush_all,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_ifetch,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import cache_pkg::*;

  localparam int LINE_WORDS = LINE_BYTES / (DATA_W / 8);
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int BSEL_W     = $clog2(DATA_W / 8);
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam int TAG_W      = ADDR_W - OFF_W - INDEX_W + 1;
  localparam int BASE_W     = ADDR_W - OFF_W;
  localparam int LINE_W     = LINE_WORDS * DATA_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

  ctl_state_e          state_q, state_d;
  logic [WSEL_W-1:0]   beat_q, beat_d;
  logic                side_q, side_d;      // 1: instruction buffer
  logic                stale_q, stale_d;
  logic [INDEX_W-1:0]  fidx_q;
  logic [BASE_W-1:0]   fbase_q;
  logic [1:0]          mode_q;

  logic                mode_chg, inval, split, cacheable, hit, start_fill;
  logic [INDEX_W-1:0]  line_idx;
  logic [TAG_W-1:0]    req_tag;
  logic [DATA_W-1:0]   rd_word;
  logic [1:0]          buf_we;
  logic [LINE_W-1:0]   buf_line [2];
  logic                tag_we, line_we, word_we;
  logic                fill_busy;

  assign mode_chg  = (cfg_mode != mode_q);
  assign inval     = flush_all || mode_chg;
  assign split     = (mode_q == MODE_SPLIT);
  assign cacheable = mode_caches(mode_q, cpu_ifetch);
  assign fill_busy = (state_q == ST_FILL);

  cache_index_map #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .INDEX_W(INDEX_W)) u_map (
    .split(split), .ifetch(cpu_ifetch), .addr_hi(cpu_addr[ADDR_W-1:OFF_W]),
    .line_idx(line_idx), .tag(req_tag)
  );

  cache_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .inval_all(inval), .split(split),
    .rd_idx(line_idx), .rd_tag(req_tag), .hit(hit),
    .wr_en(tag_we), .wr_idx(fidx_q), .wr_tag(fbase_q[BASE_W-1:INDEX_W-1])
  );

  cache_data_store #(.INDEX_W(INDEX_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_data (
    .clk(clk), .rd_widx({line_idx, cpu_addr[OFF_W-1:BSEL_W]}), .rd_word(rd_word),
    .line_we(line_we), .line_idx(fidx_q), .line_data(buf_line[side_q]),
    .word_we(word_we), .word_data(cpu_wdata)
  );

  // Index 0 collects operand lines, index 1 instruction lines.
  for (genvar g = 0; g < 2; g++) begin : g_fbuf
    cache_fill_buf #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_fbuf (
      .clk(clk), .we(buf_we[g]), .sel(beat_q), .wdata(mem_rdata), .line(buf_line[g])
    );
  end

  // Next-state and datapath controls
  always_comb begin
    state_d    = state_q;
    beat_d     = beat_q;
    side_d     = side_q;
    stale_d    = stale_q || inval;
    buf_we     = 2'b00;
    tag_we     = 1'b0;
    line_we    = 1'b0;
    word_we    = 1'b0;
    start_fill = 1'b0;
    cpu_ready  = 1'b0;
    cpu_rdata  = rd_word;
    case (state_q)
      ST_IDLE: begin
        stale_d = 1'b0;
        if (cpu_req && !inval) begin
          if (!cpu_wr && cacheable) begin
            if (hit) begin
              cpu_ready = 1'b1;
            end else begin
              state_d    = ST_FILL;
              beat_d     = '0;
              side_d     = cpu_ifetch;
              start_fill = 1'b1;
            end
          end else begin
            state_d = ST_SINGLE;
          end
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          buf_we[side_q] = 1'b1;
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            state_d = ST_IDLE;
            if (!stale_q && !inval) begin
              tag_we  = 1'b1;
              line_we = 1'b1;
            end
          end
        end
      end
      ST_SINGLE: begin
        cpu_rdata = mem_rdata;
        if (mem_ack) begin
          cpu_ready = 1'b1;
          state_d   = ST_IDLE;
          if (cpu_wr && cacheable && hit && !inval) word_we = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      side_q  <= 1'b0;
      stale_q <= 1'b0;
      mode_q  <= MODE_NONE;
      fidx_q  <= '0;
      fbase_q <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      side_q  <= side_d;
      stale_q <= stale_d;
      mode_q  <= cfg_mode;
      if (start_fill) begin
        fidx_q  <= line_idx;
        fbase_q <= cpu_addr[ADDR_W-1:OFF_W];
      end
    end
  end

  assign mem_req   = (state_q != ST_IDLE);
  assign mem_wr    = (state_q == ST_SINGLE) && cpu_wr;
  assign mem_wdata = cpu_wdata;
  assign mem_addr  = fill_busy ? {fbase_q, beat_q, {BSEL_W{1'b0}}} : cpu_addr;
endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_mode,
  input logic [1:0]        mode_now,
  input logic              flush_all,
  input logic              cpu_req,
  input logic              cpu_wr,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_wr,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fill_busy
);
  localparam int BSEL_W = 2;

  a_r1_ready_without_mem: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !mem_req |-> cpu_req && !cpu_wr);

  a_r5_store_waits_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_wr |-> mem_req && mem_wr && mem_ack);

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r2_fill_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy && mem_ack && (mem_addr[OFF_W-1:BSEL_W] != '1)
    |=> fill_busy && (mem_addr == $past(mem_addr) + ADDR_W'(4)));

  a_r12_no_ready_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !cpu_ready);

  a_r9_stall_on_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && (cfg_mode != mode_now) |-> !cpu_ready);

  a_r8_stall_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && flush_all |-> !cpu_ready);
endmodule

bind cache_ctrl cache_ctrl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .mode_now(mode_q),
  .flush_all(flush_all), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_wr(mem_wr), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .fill_busy(fill_busy)
);

// File: tb/cache_ctrl_test.sv
`timescale 1ns/1ps
module cache_ctrl_test;
  // Small configuration: 16 lines; unified index [7:4], split index [6:4].
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_mode;
  logic        flush_all;
  logic        cpu_req, cpu_wr, cpu_ifetch, cpu_ready;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        mem_req, mem_wr, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int total = 0;
  int bad   = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  bit finished = 0;
  logic [31:0] rd_hist [4];
  logic [31:0] last_wa, last_wd;
  logic [31:0] shadow [logic [31:0]];

  always #4 clk = ~clk;

  cache_ctrl #(.INDEX_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .flush_all(flush_all),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_ifetch(cpu_ifetch),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mval(input logic [31:0] a);
    if (shadow.exists(a)) return shadow[a];
    return a * 32'h0019_660D + 32'h3C6E_F35F;
  endfunction

  // Zero-wait memory model
  always @(negedge clk) begin
    mem_ack   <= mem_req;
    mem_rdata <= mval(mem_addr);
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_wr) begin
        shadow[mem_addr] = mem_wdata;
        wr_cnt++;
        last_wa = mem_addr;
        last_wd = mem_wdata;
      end else begin
        rd_cnt++;
        rd_hist[0] = rd_hist[1];
        rd_hist[1] = rd_hist[2];
        rd_hist[2] = rd_hist[3];
        rd_hist[3] = mem_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic ifc,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    bit done;
    cpu_addr = a; cpu_wr = w; cpu_ifetch = ifc; cpu_wdata = wd; cpu_req = 1'b1;
    cyc = 0; rd = '0; done = 0;
    while (!done) begin
      #2;
      cyc++;
      if (cpu_ready) begin
        rd = cpu_rdata;
        done = 1;
      end else if (cyc > 60) begin
        done = 1;
      end
      @(negedge clk);
    end
    cpu_req = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [31:0] a, input logic ifc, input int exp_cyc,
                           input string req);
    logic [31:0] rd;
    int cyc;
    access(a, 1'b0, ifc, 32'h0, rd, cyc);
    chk(rd == mval(a), req, "read data", rd, mval(a));
    chk(cyc == exp_cyc, req, "cycles", cyc, exp_cyc);
  endtask

  task automatic check_fill(input logic [31:0] base, input string req);
    for (int k = 0; k < 4; k++)
      chk(rd_hist[k] == base + 32'(4 * k), req, "fill beat address", rd_hist[k], base + 32'(4 * k));
  endtask

  // Two passes over every word of n lines: the first word of each line misses.
  task automatic sweep(input logic [31:0] base, input int n, input logic ifc, input string req);
    for (int p = 0; p < 2; p++)
      for (int l = 0; l < n; l++)
        for (int w = 0; w < 4; w++) begin
          logic [31:0] a;
          a = base + 32'(l * 16 + w * 4);
          rd_expect(a, ifc, (p == 0 && w == 0) ? 6 : 1, req);
          if (p == 0 && w == 0) check_fill(a, "R2");
        end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int cyc, r0, w0;
    rst_n = 1'b0; cfg_mode = 2'b00; flush_all = 1'b0;
    cpu_req = 1'b0; cpu_wr = 1'b0; cpu_ifetch = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(mem_req == 1'b0, "R11", "mem_req after reset", mem_req, 0);
    chk(cpu_ready == 1'b0, "R11", "cpu_ready after reset", cpu_ready, 0);
    idle(3);

    // Instruction-only mode: sweep all 16 lines
    sweep(32'h0000_3000, 16, 1'b1, "R3");
    // Operand read is not cached in this mode
    r0 = rd_cnt;
    rd_expect(32'h0000_3000, 1'b0, 2, "R7");
    rd_expect(32'h0000_3000, 1'b0, 2, "R7");
    chk(rd_cnt - r0 == 2, "R7", "bypass beats", rd_cnt - r0, 2);
    // Index conflict one array size (256 bytes) apart; bit 7 is index
    rd_expect(32'h0000_3000, 1'b1, 1, "R1");
    r0 = rd_cnt;
    rd_expect(32'h0000_3100, 1'b1, 6, "R3");
    chk(rd_cnt - r0 == 4, "R2", "fill beats", rd_cnt - r0, 4);
    rd_expect(32'h0000_3000, 1'b1, 6, "R3");
    rd_expect(32'h0000_3080, 1'b1, 1, "R3");

    // Switch to operand-only mode with a request in the same cycle
    cfg_mode = 2'b01;
    rd_expect(32'h0000_5000, 1'b0, 7, "R9");
    rd_expect(32'h0000_3080, 1'b1, 2, "R7");
    sweep(32'h0000_6000, 16, 1'b0, "R3");

    // Store hit: one write, cached word updated
    w0 = wr_cnt;
    access(32'h0000_6014, 1'b1, 1'b0, 32'hDEAD_BEEF, rd, cyc);
    chk(cyc == 2, "R5", "store cycles", cyc, 2);
    chk(wr_cnt - w0 == 1, "R5", "write beats", wr_cnt - w0, 1);
    chk(last_wa == 32'h0000_6014, "R5", "write address", last_wa, 32'h0000_6014);
    chk(last_wd == 32'hDEAD_BEEF, "R5", "write data", last_wd, 32'hDEAD_BEEF);
    rd_expect(32'h0000_6014, 1'b0, 1, "R6");
    // Store miss: no allocation, the resident line survives
    w0 = wr_cnt;
    access(32'h0000_7024, 1'b1, 1'b0, 32'h1234_5678, rd, cyc);
    chk(cyc == 2, "R5", "store miss cycles", cyc, 2);
    chk(wr_cnt - w0 == 1, "R5", "store miss write beats", wr_cnt - w0, 1);
    rd_expect(32'h0000_6024, 1'b0, 1, "R6");
    rd_expect(32'h0000_7024, 1'b0, 6, "R6");

    // Flush
    rd_expect(32'h0000_6040, 1'b0, 1, "R8");
    flush_all = 1'b1;
    idle(1);
    flush_all = 1'b0;
    rd_expect(32'h0000_6040, 1'b0, 6, "R8");
    rd_expect(32'h0000_6050, 1'b0, 6, "R8");

    // Split mode
    cfg_mode = 2'b10;
    rd_expect(32'h0000_8000, 1'b1, 7, "R9");
    rd_expect(32'h0000_8000, 1'b0, 6, "R4");
    rd_expect(32'h0000_8000, 1'b1, 1, "R4");
    rd_expect(32'h0000_8000, 1'b0, 1, "R4");
    rd_expect(32'h0000_8080, 1'b1, 6, "R4");
    rd_expect(32'h0000_8000, 1'b1, 6, "R4");
    rd_expect(32'h0000_8000, 1'b0, 1, "R4");
    sweep(32'h0000_9000, 8, 1'b1, "R4");
    sweep(32'h0000_9000, 8, 1'b0, "R4");
    for (int l = 0; l < 8; l++) begin
      rd_expect(32'h0000_9000 + 32'(l * 16), 1'b1, 1, "R4");
      rd_expect(32'h0000_9000 + 32'(l * 16), 1'b0, 1, "R4");
    end

    // No caching
    cfg_mode = 2'b11;
    idle(2);
    rd_expect(32'h0000_9000, 1'b1, 2, "R7");
    rd_expect(32'h0000_9000, 1'b0, 2, "R7");
    w0 = wr_cnt;
    access(32'h0000_9004, 1'b1, 1'b0, 32'hA5A5_0F0F, rd, cyc);
    chk(cyc == 2 && wr_cnt - w0 == 1, "R5", "uncached store", cyc, 2);

    // Back to split: old lines are gone
    cfg_mode = 2'b10;
    idle(2);
    rd_expect(32'h0000_9000, 1'b1, 6, "R9");
    rd_expect(32'h0000_9004, 1'b0, 6, "R9");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule